// File: doc/BRIEF.md
# Multi-Width Aliased Register File

This block holds eight 32-bit general-purpose registers. It has one write port and two independent read ports. Each port names a register by index and picks a view of it: the whole word, the lower half, the low byte or the high byte of that lower half. The two byte views sit side by side and together cover the lower half.

A write through a narrow view changes only the bits of that view. Every other bit of the register keeps its value. A read through a narrow view returns the selected bits zero-extended to the full word, with the view's least significant bit at bit 0.

Byte views exist only on the lower registers (indices 0 to 3). A byte-view access to any higher register is reported on a per-port illegal flag. Such a write is dropped and such a read returns zero. Reads are combinational and always show the stored contents before the coming clock edge.

Top module: `aliased_regfile`

## Requirements
- R1: After reset every register reads as zero through the word view.
- R2: View code 0 selects the whole 32-bit word. A write stores all 32 bits, and a read returns all 32 bits.
- R3: View code 1 selects bits 15:0. A write replaces only those bits and keeps bits 31:16. A read returns bits 15:0 in result bits 15:0, with zeros above.
- R4: View code 2 selects bits 7:0 and is legal only for indices 0 to 3. A write replaces only bits 7:0. A read returns them in result bits 7:0, with zeros above.
- R5: View code 3 selects bits 15:8 and is legal only for indices 0 to 3. A write takes the data from wr_data bits 7:0 and keeps all other register bits. A read returns bits 15:8 in result bits 7:0, with zeros above.
- R6: View code 2 or 3 with index 4 or higher raises the port's illegal flag in the same cycle. On the write port the register is left unchanged. On a read port the data is zero.
- R7: Read data is combinational. A read of the register being written in the same cycle returns the value held before that write.
- R8: A write changes only the addressed register. All other registers keep their values.
- R9: The two read ports operate independently, each with its own index and view.
- R10: With wr_en low no register changes, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_idx | input | 3 | Register index for the write |
| wr_view | input | 2 | View code for the write (0 word, 1 half, 2 low byte, 3 high byte) |
| wr_data | input | 32 | Write data, aligned at bit 0 for every view |
| wr_illegal | output | 1 | The write request names a byte view of a register without one |
| rd_idx | input | 2x3 | Register index per read port |
| rd_view | input | 2x2 | View code per read port |
| rd_data | output | 2x32 | Zero-extended read data per port |
| rd_illegal | output | 2 | Illegal view flag per read port |

## Verification
The bench stacks narrow writes on one register and reads the word back. A merge that clears or shifts the untouched bits shows up as a wrong upper half or a byte in the wrong lane. It hits the boundary between index 3 and index 4 with byte views. A design that decodes the limit wrongly would corrupt a register or leak nonzero read data there. It also reads a register in the same cycle it is written, which catches a design that forwards the new value, and it idles the write port with random data on the bus, which catches a design that ignores the enable.

// File: rtl/rf_pkg.sv
package rf_pkg;
    typedef enum logic [1:0] {
        VIEW_WORD = 2'd0,
        VIEW_HALF = 2'd1,
        VIEW_LOB  = 2'd2,
        VIEW_HIB  = 2'd3
    } view_e;

    localparam int VIEW_BYTE_W = 8;
endpackage

// File: rtl/rf_view_decode.sv
module rf_view_decode #(
    parameter int XLEN          = 32,
    parameter int IDX_W         = 3,
    parameter int NUM_BYTE_REGS = 4
) (
    input  logic [IDX_W-1:0]         idx,
    input  logic [1:0]               view,
    output logic                     illegal,
    output logic [XLEN-1:0]          lane_mask,
    output logic [$clog2(XLEN)-1:0]  lane_shift
);
    import rf_pkg::*;

    localparam int HALF_W = XLEN / 2;
    localparam int SH_W   = $clog2(XLEN);

    logic is_byte;

    always_comb begin
        is_byte    = 1'b0;
        lane_mask  = '1;
        lane_shift = '0;
        case (view_e'(view))
            VIEW_WORD: begin
                lane_mask = '1;
            end
            VIEW_HALF: begin
                lane_mask = {{(XLEN-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            end
            VIEW_LOB: begin
                is_byte   = 1'b1;
                lane_mask = XLEN'({VIEW_BYTE_W{1'b1}});
            end
            default: begin
                is_byte    = 1'b1;
                lane_mask  = XLEN'({VIEW_BYTE_W{1'b1}}) << VIEW_BYTE_W;
                lane_shift = SH_W'(VIEW_BYTE_W);
            end
        endcase
        illegal = is_byte && (32'(idx) >= NUM_BYTE_REGS);
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
    parameter int NUM_REGS      = 8,
    parameter int XLEN          = 32,
    parameter int IDX_W         = 3,
    parameter int NUM_BYTE_REGS = 4
) (
    input  logic [NUM_REGS-1:0][XLEN-1:0] regs,
    input  logic [IDX_W-1:0]              idx,
    input  logic [1:0]                    view,
    output logic [XLEN-1:0]               data,
    output logic                          illegal
);
    logic [XLEN-1:0]         mask;
    logic [$clog2(XLEN)-1:0] shift;
    logic [XLEN-1:0]         word;

    rf_view_decode #(
        .XLEN(XLEN), .IDX_W(IDX_W), .NUM_BYTE_REGS(NUM_BYTE_REGS)
    ) u_dec (
        .idx(idx), .view(view), .illegal(illegal),
        .lane_mask(mask), .lane_shift(shift)
    );

    always_comb begin
        word = regs[idx];
        data = illegal ? '0 : ((word & mask) >> shift);
    end
endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
    parameter int NUM_REGS      = 8,
    parameter int XLEN          = 32,
    parameter int NUM_BYTE_REGS = 4,
    parameter int NUM_RD        = 2,
    localparam int IDX_W        = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [1:0]                    wr_view,
    input  logic [XLEN-1:0]               wr_data,
    output logic                          wr_illegal,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    input  logic [NUM_RD-1:0][1:0]        rd_view,
    output logic [NUM_RD-1:0][XLEN-1:0]   rd_data,
    output logic [NUM_RD-1:0]             rd_illegal
);
    typedef struct packed {
        logic [NUM_REGS-1:0][XLEN-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [NUM_REGS-1:0][XLEN-1:0] regs_q;
    logic [XLEN-1:0]               wr_mask;
    logic [$clog2(XLEN)-1:0]       wr_shift;

    assign regs_q = st_q.regs;

    rf_view_decode #(
        .XLEN(XLEN), .IDX_W(IDX_W), .NUM_BYTE_REGS(NUM_BYTE_REGS)
    ) u_wdec (
        .idx(wr_idx), .view(wr_view), .illegal(wr_illegal),
        .lane_mask(wr_mask), .lane_shift(wr_shift)
    );

    // Next state: merge the selected lane into the addressed register.
    always_comb begin
        st_d = st_q;
        if (wr_en && !wr_illegal) begin
            st_d.regs[wr_idx] = (st_q.regs[wr_idx] & ~wr_mask)
                              | ((wr_data << wr_shift) & wr_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        rf_read_port #(
            .NUM_REGS(NUM_REGS), .XLEN(XLEN),
            .IDX_W(IDX_W), .NUM_BYTE_REGS(NUM_BYTE_REGS)
        ) u_rd (
            .regs(regs_q), .idx(rd_idx[g]), .view(rd_view[g]),
            .data(rd_data[g]), .illegal(rd_illegal[g])
        );
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int NUM_REGS = 8,
    parameter int XLEN     = 32,
    parameter int IDX_W    = 3,
    parameter int NUM_RD   = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [IDX_W-1:0]              wr_idx,
    input logic [1:0]                    wr_view,
    input logic                          wr_illegal,
    input logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    input logic [NUM_RD-1:0][1:0]        rd_view,
    input logic [NUM_RD-1:0][XLEN-1:0]   rd_data,
    input logic [NUM_RD-1:0]             rd_illegal,
    input logic [NUM_REGS-1:0][XLEN-1:0] regs_q
);
    localparam int HI = XLEN - 1;
    localparam int HW = XLEN / 2;

    AST_HALF_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd1) |=> regs_q[$past(wr_idx)][HI:HW] == $past(regs_q[wr_idx][HI:HW])); // R3

    AST_LOB_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd2) |=> regs_q[$past(wr_idx)][HI:8] == $past(regs_q[wr_idx][HI:8])); // R4

    AST_HIB_KEEPS_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd3) |=> (regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0]))
                                    && (regs_q[$past(wr_idx)][HI:16] == $past(regs_q[wr_idx][HI:16]))); // R5

    AST_ILLEGAL_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_illegal) |=> $stable(regs_q)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R10

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        AST_OTHERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && 32'(wr_idx) == i) |=> $stable(regs_q[i])); // R8
    end

    for (genvar g = 0; g < NUM_RD; g++) begin : g_port
        AST_ILLEGAL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            rd_illegal[g] |-> rd_data[g] == '0); // R6

        AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
            rd_view[g] == 2'd0 |-> rd_data[g] == regs_q[rd_idx[g]]); // R7
    end
endmodule

bind aliased_regfile rf_checker #(
    .NUM_REGS(NUM_REGS), .XLEN(XLEN), .IDX_W(IDX_W), .NUM_RD(NUM_RD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_view(wr_view), .wr_illegal(wr_illegal), .rd_idx(rd_idx),
    .rd_view(rd_view), .rd_data(rd_data), .rd_illegal(rd_illegal),
    .regs_q(regs_q)
);

// File: tb/sim_aliased_regfile.sv
`timescale 1ns/1ps
module sim_aliased_regfile;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_idx = '0;
    logic [1:0]      wr_view = '0;
    logic [31:0]     wr_data = '0;
    logic            wr_illegal;
    logic [1:0][2:0] rd_idx = '0;
    logic [1:0][1:0] rd_view = '0;
    logic [1:0][31:0] rd_data;
    logic [1:0]      rd_illegal;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [8];

    always #4 clk = ~clk;

    aliased_regfile u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_view(wr_view), .wr_data(wr_data), .wr_illegal(wr_illegal),
        .rd_idx(rd_idx), .rd_view(rd_view), .rd_data(rd_data),
        .rd_illegal(rd_illegal)
    );

    function automatic logic f_ill(logic [2:0] idx, logic [1:0] v);
        return (v >= 2'd2) && (idx >= 3'd4);
    endfunction

    function automatic logic [31:0] f_read(logic [31:0] w, logic [2:0] idx, logic [1:0] v);
        if (f_ill(idx, v)) return 32'h0;
        case (v)
            2'd0: return w;
            2'd1: return {16'h0, w[15:0]};
            2'd2: return {24'h0, w[7:0]};
            default: return {24'h0, w[15:8]};
        endcase
    endfunction

    function automatic logic [31:0] f_merge(logic [31:0] w, logic [31:0] d, logic [1:0] v);
        case (v)
            2'd0: return d;
            2'd1: return {w[31:16], d[15:0]};
            2'd2: return {w[31:8], d[7:0]};
            default: return {w[31:16], d[7:0], w[7:0]};
        endcase
    endfunction

    function automatic string f_tag(logic [2:0] idx, logic [1:0] v);
        if (f_ill(idx, v)) return "R6";
        case (v)
            2'd0: return "R2";
            2'd1: return "R3";
            2'd2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, update model at posedge.
    task automatic cyc(logic we, logic [2:0] wi, logic [1:0] wv, logic [31:0] wd,
                       logic [2:0] i0, logic [1:0] v0, logic [2:0] i1, logic [1:0] v1,
                       string tag);
        logic [31:0] e0, e1;
        @(negedge clk);
        wr_en = we; wr_idx = wi; wr_view = wv; wr_data = wd;
        rd_idx[0] = i0; rd_view[0] = v0; rd_idx[1] = i1; rd_view[1] = v1;
        #1;
        e0 = f_read(model[i0], i0, v0);
        e1 = f_read(model[i1], i1, v1);
        chk(rd_data[0] == e0, (tag != "") ? tag : f_tag(i0, v0), rd_data[0], e0);
        chk(rd_data[1] == e1, (tag != "") ? tag : f_tag(i1, v1), rd_data[1], e1);
        chk(rd_illegal[0] == f_ill(i0, v0), "R6", 32'(rd_illegal[0]), 32'(f_ill(i0, v0)));
        chk(rd_illegal[1] == f_ill(i1, v1), "R6", 32'(rd_illegal[1]), 32'(f_ill(i1, v1)));
        chk(wr_illegal == f_ill(wi, wv), "R6", 32'(wr_illegal), 32'(f_ill(wi, wv)));
        @(posedge clk);
        if (we && !f_ill(wi, wv)) model[wi] = f_merge(model[wi], wd, wv);
    endtask

    task automatic dump(string tag);
        for (int i = 0; i < 8; i++)
            cyc(1'b0, 3'(i), 2'd0, $urandom, 3'(i), 2'd0, 3'(7 - i), 2'd0, tag);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 8; i++) model[i] = 32'h0;
        wr_data = 32'hFFFF_FFFF; wr_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; wr_en = 1'b0;
        dump("R1");

        // Narrow writes stacked on register 0 (R2..R5)
        cyc(1, 3'd0, 2'd0, 32'hA1B2C3D4, 3'd0, 2'd0, 3'd1, 2'd0, "");
        cyc(1, 3'd0, 2'd1, 32'hEEEE1234, 3'd0, 2'd0, 3'd0, 2'd1, "R2");
        cyc(1, 3'd0, 2'd2, 32'hFFFFFF99, 3'd0, 2'd0, 3'd0, 2'd1, "R3");
        cyc(1, 3'd0, 2'd3, 32'hFFFFFF77, 3'd0, 2'd0, 3'd0, 2'd2, "R4");
        cyc(0, 3'd0, 2'd0, 32'h0,        3'd0, 2'd0, 3'd0, 2'd3, "R5");
        chk(rd_data[0] == 32'hA1B27799, "R5", rd_data[0], 32'hA1B27799);

        // Index boundary 3/4 with byte views (R6)
        cyc(1, 3'd3, 2'd3, 32'h000000C3, 3'd3, 2'd3, 3'd4, 2'd2, "");
        cyc(1, 3'd4, 2'd0, 32'hCAFEF00D, 3'd4, 2'd0, 3'd3, 2'd3, "");
        cyc(1, 3'd4, 2'd2, 32'h00000011, 3'd4, 2'd2, 3'd4, 2'd3, "R6");
        cyc(1, 3'd7, 2'd3, 32'h00000022, 3'd4, 2'd0, 3'd7, 2'd2, "R6");
        cyc(0, 3'd0, 2'd0, 32'h0, 3'd4, 2'd0, 3'd7, 2'd0, "R6");

        // Same-cycle read of the register being written returns old value (R7)
        cyc(1, 3'd2, 2'd0, 32'h55AA55AA, 3'd2, 2'd0, 3'd2, 2'd1, "R7");
        cyc(1, 3'd2, 2'd2, 32'h00000011, 3'd2, 2'd0, 3'd2, 2'd2, "R7");

        // Independent read ports (R9)
        cyc(0, 3'd0, 2'd0, 32'h0, 3'd0, 2'd3, 3'd4, 2'd1, "R9");

        // Idle write port with random data (R10)
        for (int k = 0; k < 20; k++)
            cyc(1'b0, 3'($urandom), 2'($urandom), $urandom, 3'($urandom), 2'($urandom),
                3'($urandom), 2'($urandom), "R10");
        dump("R10");

        // Random traffic, then full readback (R8)
        for (int k = 0; k < 3000; k++)
            cyc(1'($urandom), 3'($urandom), 2'($urandom), $urandom, 3'($urandom),
                2'($urandom), 3'($urandom), 2'($urandom), "");
        dump("R8");
        summary();
    end
endmodule